// File: doc/BRIEF.md
# Four-Mode Preamble and Header Framer

This block produces the serial bit stream that opens a packet: an all-ones synchronisation run followed by a header. The header's field set depends on a 2-bit protocol mode. A start pulse captures the whole configuration. These values are the mode, the sync-run length, the frame delimiter, the service byte, the length word, the two signal-code bytes and the payload-modulation select. The block then offers one bit at a time on `bit_o`. Each symbol strobe consumes the bit on offer and moves to the next one.

A built-in CRC-16 unit covers the header fields that lie between the frame delimiter and the check field. The block appends the complemented remainder as the last header field, and `crc_prot_o` marks the bits the CRC covers. The block always sends the sync run and the header in DBPSK. When the last header bit has gone, it pulses `hdr_done_o` and drives `payload_qpsk_o` with the modulation the payload must use.

Top module: `hdr_framer`

## Requirements
- R1: The stream opens with a run of `pre_len_i` one-bits, counted 0 to 255. A count of 0 gives no run, and the frame delimiter comes first.
- R2: The field order is sync run, delimiter (16 bits), signal (8), service (8), length (16), check (16). Mode 0 sends only the delimiter. Mode 1 sends the delimiter and the check. Mode 2 sends the delimiter, length and check. Mode 3 sends all five fields.
- R3: The delimiter, signal, service and length fields go out least significant bit first.
- R4: In mode 3 the signal byte is `sig_qpsk_i` when `qpsk_sel_i` is 1 and `sig_bpsk_i` when it is 0.
- R5: The CRC register is preset to all ones when the delimiter ends. The polynomial is x^16+x^12+x^5+1 (0x1021), shifted MSB-side, and it processes the present signal, service and length bits in transmit order. The check field is the bitwise complement of the register, most significant bit first. `crc_prot_o` is 1 on exactly the signal, service and length bits.
- R6: `bit_o` holds until a symbol strobe. Each strobe seen while busy moves the stream on by exactly one bit.
- R7: `start_i` is taken only while idle. `busy_o` is 1 from the next cycle. All configuration inputs are captured at that start. Later changes to them, and any start pulse while busy, have no effect on the frame.
- R8: `hdr_done_o` is a one-cycle pulse in the cycle after the strobe that consumes the last header bit. `busy_o` falls in that same cycle.
- R9: `payload_qpsk_o` is 0 while busy. From the done pulse until the next start it equals the captured `qpsk_sel_i`. In mode 0 it stays 0.
- R10: After reset and whenever idle, `busy_o`, `bit_o`, `crc_prot_o`, `hdr_done_o` and `payload_qpsk_o` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Begin a frame (taken when idle) |
| sym_stb_i | input | 1 | Symbol strobe; consumes the offered bit |
| mode_i | input | 2 | Protocol mode 0..3 |
| pre_len_i | input | 8 | Sync-run length in bits |
| sfd_i | input | 16 | Frame delimiter value |
| sig_bpsk_i | input | 8 | Signal code for DBPSK payload |
| sig_qpsk_i | input | 8 | Signal code for DQPSK payload |
| qpsk_sel_i | input | 1 | Payload modulation select, 1 = DQPSK |
| service_i | input | 8 | Service field value |
| length_i | input | 16 | Length field value |
| bit_o | output | 1 | Bit currently offered |
| crc_prot_o | output | 1 | Offered bit is CRC-covered |
| busy_o | output | 1 | Frame in progress |
| hdr_done_o | output | 1 | Last header bit consumed (one cycle) |
| payload_qpsk_o | output | 1 | Payload modulation flag, 1 = DQPSK |

## Verification
The first bit is on offer one cycle after an accepted start. A strobe at a rising edge changes `bit_o` and `crc_prot_o` by the following falling edge. `hdr_done_o`, the fall of `busy_o` and the settled `payload_qpsk_o` all appear one cycle after the final strobe. The bench drives and samples only on falling edges, reads each bit before it raises the strobe, and checks the done pulse at the first falling edge after the final strobe and its clearing at the one after. Idle gaps between strobes let the bench test that the offered bit holds when no strobe comes.

// File: rtl/hdr_framer_pkg.sv
package hdr_framer_pkg;

  typedef enum logic [2:0] {
    FLD_IDLE,
    FLD_PRE,
    FLD_SFD,
    FLD_SIG,
    FLD_SVC,
    FLD_LEN,
    FLD_CRC
  } fld_e;

  // next present field after f for protocol mode m
  function automatic fld_e fld_after(fld_e f, logic [1:0] m);
    case (f)
      FLD_PRE: return FLD_SFD;
      FLD_SFD: begin
        case (m)
          2'd3:    return FLD_SIG;
          2'd2:    return FLD_LEN;
          2'd1:    return FLD_CRC;
          default: return FLD_IDLE;
        endcase
      end
      FLD_SIG: return FLD_SVC;
      FLD_SVC: return FLD_LEN;
      FLD_LEN: return FLD_CRC;
      default: return FLD_IDLE;
    endcase
  endfunction

  function automatic logic fld_protected(fld_e f);
    return (f == FLD_SIG) || (f == FLD_SVC) || (f == FLD_LEN);
  endfunction

endpackage

// File: rtl/hdr_crc16.sv
module hdr_crc16 #(
  parameter int           W    = 16,
  parameter logic [W-1:0] POLY = 16'h1021
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         clr_i,
  input  logic         en_i,
  input  logic         din_i,
  output logic [W-1:0] crc_d_o
);

  logic [W-1:0] crc_q;
  logic         fb;

  assign fb = crc_q[W-1] ^ din_i;

  always_comb begin
    if (clr_i)     crc_d_o = '1;
    else if (en_i) crc_d_o = {crc_q[W-2:0], 1'b0} ^ (fb ? POLY : '0);
    else           crc_d_o = crc_q;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) crc_q <= '1;
    else         crc_q <= crc_d_o;
  end

endmodule

// File: rtl/hdr_seq_ctrl.sv
module hdr_seq_ctrl
  import hdr_framer_pkg::*;
#(
  parameter int PRE_W = 8,
  parameter int CNT_W = 8,
  parameter int SFD_W = 16,
  parameter int SIG_W = 8,
  parameter int SVC_W = 8,
  parameter int LEN_W = 16,
  parameter int CRC_W = 16
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             start_i,    // already gated with idle
  input  logic             stb_i,
  input  logic [1:0]       mode_i,
  input  logic [PRE_W-1:0] pre_len_i,
  output fld_e             fld_o,
  output fld_e             nxt_fld_o,
  output logic             load_o,
  output logic             adv_o,
  output logic             crc_clr_o,
  output logic             done_o
);

  fld_e             fld_q;
  logic [CNT_W-1:0] idx_q;
  logic [CNT_W-1:0] fld_len;
  logic [1:0]       mode_q;
  logic [PRE_W-1:0] pre_len_q;
  logic             done_q;
  logic             last;
  fld_e             follow;

  always_comb begin
    case (fld_q)
      FLD_PRE: fld_len = CNT_W'(pre_len_q);
      FLD_SFD: fld_len = CNT_W'(SFD_W);
      FLD_SIG: fld_len = CNT_W'(SIG_W);
      FLD_SVC: fld_len = CNT_W'(SVC_W);
      FLD_LEN: fld_len = CNT_W'(LEN_W);
      FLD_CRC: fld_len = CNT_W'(CRC_W);
      default: fld_len = CNT_W'(1);
    endcase
  end

  assign last      = (idx_q == fld_len - CNT_W'(1));
  assign follow    = fld_after(fld_q, mode_q);
  assign adv_o     = stb_i && (fld_q != FLD_IDLE);
  assign load_o    = start_i || (adv_o && last);
  assign nxt_fld_o = start_i ? ((pre_len_i != '0) ? FLD_PRE : FLD_SFD) : follow;
  assign crc_clr_o = start_i || (adv_o && last && (fld_q == FLD_SFD));
  assign fld_o     = fld_q;
  assign done_o    = done_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      fld_q     <= FLD_IDLE;
      idx_q     <= '0;
      mode_q    <= '0;
      pre_len_q <= '0;
      done_q    <= 1'b0;
    end else begin
      done_q <= adv_o && last && (follow == FLD_IDLE);
      if (start_i) begin
        mode_q    <= mode_i;
        pre_len_q <= pre_len_i;
      end
      if (load_o) begin
        fld_q <= nxt_fld_o;
        idx_q <= '0;
      end else if (adv_o) begin
        idx_q <= idx_q + CNT_W'(1);
      end
    end
  end

endmodule

// File: rtl/hdr_framer.sv
module hdr_framer
  import hdr_framer_pkg::*;
#(
  parameter int PRE_W = 8,
  parameter int SFD_W = 16,
  parameter int SIG_W = 8,
  parameter int SVC_W = 8,
  parameter int LEN_W = 16,
  parameter int CRC_W = 16,
  parameter logic [CRC_W-1:0] CRC_POLY = 16'h1021
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             start_i,
  input  logic             sym_stb_i,
  input  logic [1:0]       mode_i,
  input  logic [PRE_W-1:0] pre_len_i,
  input  logic [SFD_W-1:0] sfd_i,
  input  logic [SIG_W-1:0] sig_bpsk_i,
  input  logic [SIG_W-1:0] sig_qpsk_i,
  input  logic             qpsk_sel_i,
  input  logic [SVC_W-1:0] service_i,
  input  logic [LEN_W-1:0] length_i,
  output logic             bit_o,
  output logic             crc_prot_o,
  output logic             busy_o,
  output logic             hdr_done_o,
  output logic             payload_qpsk_o
);

  localparam int W_A   = (SFD_W > SIG_W) ? SFD_W : SIG_W;
  localparam int W_B   = (SVC_W > LEN_W) ? SVC_W : LEN_W;
  localparam int W_C   = (W_A > W_B) ? W_A : W_B;
  localparam int SH_W  = (W_C > CRC_W) ? W_C : CRC_W;
  localparam int FIX_W = $clog2(SH_W + 1);
  localparam int CNT_W = (PRE_W > FIX_W) ? PRE_W : FIX_W;

  fld_e             fld, nxt_fld;
  logic             load, adv, crc_clr, start_acc, prot;
  logic [SFD_W-1:0] sfd_q, sfd_src;
  logic [SIG_W-1:0] sig_q;
  logic [SVC_W-1:0] svc_q;
  logic [LEN_W-1:0] len_q;
  logic             pay_q;
  logic [SH_W-1:0]  sh_q, ld_val;
  logic [CRC_W-1:0] crc_d, crc_rev;

  assign busy_o    = (fld != FLD_IDLE);
  assign start_acc = start_i && !busy_o;
  assign prot      = fld_protected(fld);

  hdr_seq_ctrl #(
    .PRE_W(PRE_W), .CNT_W(CNT_W), .SFD_W(SFD_W), .SIG_W(SIG_W),
    .SVC_W(SVC_W), .LEN_W(LEN_W), .CRC_W(CRC_W)
  ) u_ctrl (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .start_i   (start_acc),
    .stb_i     (sym_stb_i),
    .mode_i    (mode_i),
    .pre_len_i (pre_len_i),
    .fld_o     (fld),
    .nxt_fld_o (nxt_fld),
    .load_o    (load),
    .adv_o     (adv),
    .crc_clr_o (crc_clr),
    .done_o    (hdr_done_o)
  );

  hdr_crc16 #(.W(CRC_W), .POLY(CRC_POLY)) u_crc (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .clr_i   (crc_clr),
    .en_i    (adv && prot),
    .din_i   (sh_q[0]),
    .crc_d_o (crc_d)
  );

  // check field leaves MSB first through an LSB-first shifter
  for (genvar g = 0; g < CRC_W; g++) begin : g_crc_rev
    assign crc_rev[g] = ~crc_d[CRC_W-1-g];
  end

  // delimiter may follow start directly, before the capture lands
  assign sfd_src = start_acc ? sfd_i : sfd_q;

  always_comb begin
    case (nxt_fld)
      FLD_SFD: ld_val = SH_W'(sfd_src);
      FLD_SIG: ld_val = SH_W'(sig_q);
      FLD_SVC: ld_val = SH_W'(svc_q);
      FLD_LEN: ld_val = SH_W'(len_q);
      FLD_CRC: ld_val = SH_W'(crc_rev);
      default: ld_val = '0;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sfd_q <= '0;
      sig_q <= '0;
      svc_q <= '0;
      len_q <= '0;
      pay_q <= 1'b0;
      sh_q  <= '0;
    end else begin
      if (start_acc) begin
        sfd_q <= sfd_i;
        sig_q <= qpsk_sel_i ? sig_qpsk_i : sig_bpsk_i;
        svc_q <= service_i;
        len_q <= length_i;
        pay_q <= qpsk_sel_i && (mode_i != 2'd0);
      end
      if (load)     sh_q <= ld_val;
      else if (adv) sh_q <= {1'b0, sh_q[SH_W-1:1]};
    end
  end

  assign bit_o          = busy_o && ((fld == FLD_PRE) || sh_q[0]);
  assign crc_prot_o     = prot;
  assign payload_qpsk_o = pay_q && !busy_o;

endmodule

// File: rtl/hdr_framer_chk.sv
module hdr_framer_chk (
  input logic clk_i,
  input logic rst_ni,
  input logic start_i,
  input logic sym_stb_i,
  input logic bit_o,
  input logic crc_prot_o,
  input logic busy_o,
  input logic hdr_done_o,
  input logic payload_qpsk_o
);

  AST_BIT_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_o && !sym_stb_i) |=> $stable(bit_o)); // R6

  AST_DONE_SINGLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    hdr_done_o |=> !hdr_done_o); // R8

  AST_DONE_ENDS_FRAME: assert property (@(posedge clk_i) disable iff (!rst_ni)
    hdr_done_o |-> (!busy_o && $past(busy_o))); // R8

  AST_HDR_DBPSK: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_o |-> !payload_qpsk_o); // R9

  AST_PROT_IN_FRAME: assert property (@(posedge clk_i) disable iff (!rst_ni)
    crc_prot_o |-> busy_o); // R5

  AST_START_TAKEN: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (start_i && !busy_o) |=> busy_o); // R7

  AST_IDLE_QUIET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !busy_o |-> (!bit_o && !crc_prot_o)); // R10

endmodule

bind hdr_framer hdr_framer_chk u_chk (
  .clk_i          (clk_i),
  .rst_ni         (rst_ni),
  .start_i        (start_i),
  .sym_stb_i      (sym_stb_i),
  .bit_o          (bit_o),
  .crc_prot_o     (crc_prot_o),
  .busy_o         (busy_o),
  .hdr_done_o     (hdr_done_o),
  .payload_qpsk_o (payload_qpsk_o)
);

// File: tb/hdr_framer_tb_top.sv
module hdr_framer_tb_top;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start = 1'b0;
  logic        stb = 1'b0;
  logic [1:0]  mode = '0;
  logic [7:0]  pre_len = '0;
  logic [15:0] sfd = '0;
  logic [7:0]  sig_b = '0;
  logic [7:0]  sig_q = '0;
  logic        qsel = 1'b0;
  logic [7:0]  svc = '0;
  logic [15:0] len = '0;
  logic        bit_w, prot_w, busy_w, done_w, pay_w;

  int n_tests = 0;
  int n_fail  = 0;
  bit finished = 1'b0;

  always #4 clk = ~clk;  // 125 MHz

  hdr_framer dut_i (
    .clk_i(clk), .rst_ni(rst_n), .start_i(start), .sym_stb_i(stb),
    .mode_i(mode), .pre_len_i(pre_len), .sfd_i(sfd), .sig_bpsk_i(sig_b),
    .sig_qpsk_i(sig_q), .qpsk_sel_i(qsel), .service_i(svc), .length_i(len),
    .bit_o(bit_w), .crc_prot_o(prot_w), .busy_o(busy_w),
    .hdr_done_o(done_w), .payload_qpsk_o(pay_w)
  );

  task automatic chk(input bit ok, input string req, input string what,
                     input longint act, input longint exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  function automatic logic [15:0] crc_step(logic [15:0] c, logic b);
    logic fb = c[15] ^ b;
    return {c[14:0], 1'b0} ^ (fb ? 16'h1021 : 16'h0000);
  endfunction

  task automatic test_reset();
    @(negedge clk);
    chk(!busy_w && !bit_w && !prot_w && !done_w && !pay_w, "R10", "idle outputs",
        {busy_w, bit_w, prot_w, done_w, pay_w}, 0);
  endtask

  task automatic run_frame(input string tag, input logic [1:0] m, input logic [7:0] pl,
                           input logic qs, input logic [15:0] f_sfd, input logic [7:0] f_sb,
                           input logic [7:0] f_sq, input logic [7:0] f_svc,
                           input logic [15:0] f_len, input int gap, input bit disturb);
    bit          e_bit [0:511];
    bit          e_prot[0:511];
    int          n = 0;
    logic [15:0] c = 16'hFFFF;
    logic [7:0]  sg;
    int          bad_bit = 0, bad_prot = 0, bad_hold = 0, first_bad = -1;
    logic        exp_pay;

    // expected stream (R1..R5)
    for (int i = 0; i < pl; i++) begin e_bit[n] = 1'b1; e_prot[n] = 1'b0; n++; end
    for (int i = 0; i < 16; i++) begin e_bit[n] = f_sfd[i]; e_prot[n] = 1'b0; n++; end
    if (m == 2'd3) begin
      sg = qs ? f_sq : f_sb;
      for (int i = 0; i < 8; i++) begin e_bit[n] = sg[i]; e_prot[n] = 1'b1; c = crc_step(c, sg[i]); n++; end
      for (int i = 0; i < 8; i++) begin e_bit[n] = f_svc[i]; e_prot[n] = 1'b1; c = crc_step(c, f_svc[i]); n++; end
    end
    if (m >= 2'd2)
      for (int i = 0; i < 16; i++) begin e_bit[n] = f_len[i]; e_prot[n] = 1'b1; c = crc_step(c, f_len[i]); n++; end
    if (m >= 2'd1)
      for (int i = 0; i < 16; i++) begin e_bit[n] = ~c[15-i]; e_prot[n] = 1'b0; n++; end
    exp_pay = qs && (m != 2'd0);

    @(negedge clk);
    mode = m; pre_len = pl; qsel = qs; sfd = f_sfd; sig_b = f_sb; sig_q = f_sq;
    svc = f_svc; len = f_len; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    chk(busy_w == 1'b1, "R7", {tag, " busy after start"}, busy_w, 1);
    chk(pay_w == 1'b0, "R9", {tag, " payload flag low in header"}, pay_w, 0);

    for (int i = 0; i < n; i++) begin
      for (int g = 0; g < gap; g++) begin
        if (bit_w !== e_bit[i]) bad_hold++;
        @(negedge clk);
      end
      if (bit_w !== e_bit[i] || !busy_w) begin
        bad_bit++;
        if (first_bad < 0) first_bad = i;
      end
      if (prot_w !== e_prot[i]) bad_prot++;
      if (disturb && i == n / 2) begin
        // start while busy and new config: both ignored (R7)
        start = 1'b1; mode = ~m; pre_len = 8'd1; qsel = ~qs; sfd = ~f_sfd;
        sig_b = ~f_sb; sig_q = ~f_sq; svc = ~f_svc; len = ~f_len;
      end
      stb = 1'b1;
      @(negedge clk);
      stb = 1'b0;
      start = 1'b0;
    end

    chk(bad_bit == 0, "R2", {tag, " bit stream mismatches (first index)"}, bad_bit, 0);
    if (bad_bit != 0) $display("  first mismatching bit index %0d", first_bad);
    chk(bad_prot == 0, "R5", {tag, " crc_prot marking mismatches"}, bad_prot, 0);
    if (gap > 0) chk(bad_hold == 0, "R6", {tag, " bit changed without strobe"}, bad_hold, 0);
    chk(done_w == 1'b1, "R8", {tag, " done pulse after last strobe"}, done_w, 1);
    chk(busy_w == 1'b0, "R8", {tag, " busy falls with done"}, busy_w, 0);
    chk(pay_w == exp_pay, "R9", {tag, " payload modulation flag"}, pay_w, exp_pay);
    @(negedge clk);
    chk(done_w == 1'b0, "R8", {tag, " done lasts one cycle"}, done_w, 0);
    chk(pay_w == exp_pay, "R9", {tag, " payload flag held"}, pay_w, exp_pay);
    chk(!bit_w && !prot_w, "R10", {tag, " idle bit and mark"}, {bit_w, prot_w}, 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    test_reset();                                                            // R10
    run_frame("m0_pre8",   2'd0, 8'd8,   1'b1, 16'hF3A0, 8'h0A, 8'h14, 8'h5C, 16'h0123, 0, 1'b0); // R1 R2 R9
    run_frame("m1_pre0",   2'd1, 8'd0,   1'b1, 16'h05CF, 8'h0A, 8'h14, 8'h00, 16'h0000, 1, 1'b0); // R1 R5
    run_frame("m2_pre3",   2'd2, 8'd3,   1'b0, 16'hA55A, 8'h0A, 8'h14, 8'h77, 16'h1234, 2, 1'b0); // R3 R5
    run_frame("m3_bpsk",   2'd3, 8'd16,  1'b0, 16'hF3A0, 8'h0A, 8'h14, 8'h81, 16'hBEEF, 0, 1'b0); // R4
    run_frame("m3_qpsk",   2'd3, 8'd5,   1'b1, 16'h1357, 8'h0A, 8'h14, 8'h3C, 16'h00FF, 1, 1'b1); // R4 R7
    run_frame("m3_pre255", 2'd3, 8'd255, 1'b1, 16'hC0DE, 8'hA5, 8'h5A, 8'hFF, 16'hFFFF, 0, 1'b0); // R1 R4
    finished = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      n_tests++;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

endmodule